// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo audio from a three-wire serial link made of a bit clock, a word clock that marks the active channel, and a data line. It turns the stream into parallel left and right samples of 24 bits. The bit clock and the word clock are not used as clocks. They are sampled in the system clock domain, and a rising bit-clock level seen there acts as a bit enable. Samples are two's complement, most significant bit first, and the left channel always occupies the first half of a frame.

A 2-bit format input selects one of four framings. In two of them the word is anchored to the start of a half-frame. In the other two it is anchored to the end, right before the word clock changes. Words shorter than 24 bits are left-aligned in the output with zeros in the low bits. Each completed stereo pair is offered on a valid/ready output. The pair stays on the output until it is accepted. If a newer pair completes before the held pair is accepted, the newer pair replaces it and `out_valid` stays high, so at most one pair is ever pending.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_sel` = 00 (I2S), word clock low marks the left channel. The MSB is taken on the second rising bit-clock edge after a word-clock change.
- R2: With `fmt_sel` = 01 (left justified), word clock high marks the left channel. The MSB is taken on the first rising bit-clock edge after a word-clock change.
- R3: With `fmt_sel` = 10 (right justified, 24 bits), word clock high marks the left channel. The sample is the last 24 bits received before the word clock changes, so the LSB is on the final bit clock of the half-frame.
- R4: With `fmt_sel` = 11 (right justified, 16 bits), word clock high marks the left channel. The last 16 bits before the word-clock change form output bits 23:8, and bits 7:0 are zero.
- R5: In formats 00 and 01, bits after the 24th in a half-frame have no effect on the sample.
- R6: In formats 00 and 01, a half-frame that carries fewer than 24 bits yields the received bits left-aligned, with zeros in the missing low bits.
- R7: A stereo pair is produced once, when the right half-frame closes, that is when the word clock returns to its left level. Each full frame sent after the link is aligned yields exactly one pair.
- R8: `out_valid` holds until `out_ready` is high at a clock edge. While `out_valid` is held, the data stays unchanged unless a newer pair completes, and then the newer pair replaces it.
- R9: During and right after reset, `out_valid` is low and both sample outputs are zero. The half-frame that is in progress when reset is released is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left justified, 10 right justified 24-bit, 11 right justified 16-bit |
| bclk | input | 1 | Serial bit clock, sampled as a level |
| wclk | input | 1 | Word clock marking the active channel |
| sdata | input | 1 | Serial data, MSB first |
| out_ready | input | 1 | Consumer accepts the pair on an edge where valid is high |
| out_valid | output | 1 | A stereo pair is on the outputs |
| out_left | output | 24 | Left sample, left-aligned |
| out_right | output | 24 | Right sample, left-aligned |

## Verification
The bench uses the default build: 24-bit output, 16-bit short words and two input register stages. It drives each bit over eight system clocks. With this setup it can sweep all four framings over half-frame lengths of 16, 24 and 32 bit clocks, and over word lengths from 16 up to 32 bits. That covers truncation, zero-fill and the position of the MSB relative to the word-clock edge. Every sample value is checked against a value computed by shifting in the bench. One run holds `out_ready` low during a whole stream to exercise the replace-while-held rule.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ16 = 2'b11
  } aud_fmt_e;

  typedef struct packed {
    logic sck;
    logic ws;
    logic sd;
  } aud_pins_t;

endpackage

// File: rtl/aud_pin_sampler.sv
module aud_pin_sampler
  import aud_rx_pkg::*;
#(
  parameter int IN_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  aud_pins_t pins_in,
  output logic      bit_stb,
  output logic      ws_bit,
  output logic      sd_bit
);

  aud_pins_t stage_q [IN_STAGES];
  logic      sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IN_STAGES; i++) stage_q[i] <= '0;
      sck_prev <= 1'b0;
    end else begin
      stage_q[0] <= pins_in;
      for (int i = 1; i < IN_STAGES; i++) stage_q[i] <= stage_q[i-1];
      sck_prev <= stage_q[IN_STAGES-1].sck;
    end
  end

  // one-cycle enable on a rising bit-clock level
  assign bit_stb = stage_q[IN_STAGES-1].sck & ~sck_prev;
  assign ws_bit  = stage_q[IN_STAGES-1].ws;
  assign sd_bit  = stage_q[IN_STAGES-1].sd;

endmodule

// File: rtl/aud_frame_tracker.sv
module aud_frame_tracker
  import aud_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  aud_fmt_e fmt,
  input  logic     bit_stb,
  input  logic     ws_bit,
  output logic     bnd,
  output logic     word_stb,
  output logic     closing_left
);

  logic       ws_h1, ws_h2;
  logic [1:0] hist;
  logic       armed;
  logic       is_i2s, ws_cur, ws_old, primed;

  // I2S is handled as left justified with the word clock delayed one bit
  always_comb begin
    is_i2s       = (fmt == FMT_I2S);
    ws_cur       = is_i2s ? ws_h1 : ws_bit;
    ws_old       = is_i2s ? ws_h2 : ws_h1;
    primed       = is_i2s ? (hist == 2'd2) : (hist != 2'd0);
    bnd          = bit_stb && primed && (ws_cur != ws_old);
    word_stb     = bnd && armed;
    closing_left = is_i2s ? ~ws_old : ws_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_h1 <= 1'b0;
      ws_h2 <= 1'b0;
      hist  <= 2'd0;
      armed <= 1'b0;
    end else if (bit_stb) begin
      ws_h1 <= ws_bit;
      ws_h2 <= ws_h1;
      if (hist != 2'd2) hist <= hist + 2'd1;
      if (bnd) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/aud_word_assembler.sv
module aud_word_assembler
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  aud_fmt_e            fmt,
  input  logic                bit_stb,
  input  logic                sd_bit,
  input  logic                bnd,
  output logic [SAMPLE_W-1:0] word
);

  localparam int CW    = $clog2(SAMPLE_W + 1);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] acc, acc_nxt, sr;
  logic [CW-1:0]       cnt;

  always_comb begin
    acc_nxt = acc;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (cnt == CW'(SAMPLE_W - 1 - i)) acc_nxt[i] = sd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      sr  <= '0;
      cnt <= '0;
    end else if (bit_stb) begin
      sr <= {sr[SAMPLE_W-2:0], sd_bit};
      if (bnd) begin
        acc <= {sd_bit, {(SAMPLE_W-1){1'b0}}};
        cnt <= CW'(1);
      end else if (cnt != CW'(SAMPLE_W)) begin
        acc <= acc_nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // word closed at the boundary bit, before that bit is taken in
  always_comb begin
    case (fmt)
      FMT_RJ24: word = sr;
      FMT_RJ16: word = {sr[SHORT_W-1:0], {PAD_W{1'b0}}};
      default:  word = acc;
    endcase
  end

endmodule

// File: rtl/aud_pair_out.sv
module aud_pair_out #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_stb,
  input  logic                closing_left,
  input  logic [SAMPLE_W-1:0] word,
  input  logic                out_ready,
  output logic                pair_stb,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);

  logic [SAMPLE_W-1:0] left_hold;
  logic                left_ok;

  assign pair_stb = word_stb && !closing_left && left_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (word_stb && closing_left) begin
        left_hold <= word;
        left_ok   <= 1'b1;
      end
      if (pair_stb) begin
        out_left  <= left_hold;
        out_right <= word;
        out_valid <= 1'b1;
        left_ok   <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SHORT_W   = 16,
  parameter int IN_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdata,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);

  aud_fmt_e            fmt;
  aud_pins_t           pins;
  logic                bit_stb, ws_bit, sd_bit;
  logic                bnd, word_stb, closing_left, pair_stb;
  logic [SAMPLE_W-1:0] word;

  assign fmt  = aud_fmt_e'(fmt_sel);
  assign pins = '{sck: bclk, ws: wclk, sd: sdata};

  aud_pin_sampler #(.IN_STAGES(IN_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins_in(pins),
    .bit_stb(bit_stb), .ws_bit(ws_bit), .sd_bit(sd_bit)
  );

  aud_frame_tracker u_track (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bit_stb(bit_stb), .ws_bit(ws_bit),
    .bnd(bnd), .word_stb(word_stb), .closing_left(closing_left)
  );

  aud_word_assembler #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bit_stb(bit_stb), .sd_bit(sd_bit),
    .bnd(bnd), .word(word)
  );

  aud_pair_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .closing_left(closing_left),
    .word(word), .out_ready(out_ready), .pair_stb(pair_stb),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt_sel,
  input logic                out_ready,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                pair_stb
);

  localparam int PAD_W = SAMPLE_W - SHORT_W;

  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_pair_raises_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> out_valid);

  assert_valid_from_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pair_stb));

  assert_valid_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pair_stb) |=> ($stable(out_left) && $stable(out_right)));

  assert_short_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_sel == 2'b11) |->
      (out_left[PAD_W-1:0] == '0 && out_right[PAD_W-1:0] == '0));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .out_ready(out_ready),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
  .pair_stb(pair_stb)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;

  localparam int NF   = 4;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int n_chk = 0;
  int n_fail = 0;
  int got_n = 0;
  logic [23:0] got_l [16];
  logic [23:0] got_r [16];
  logic [23:0] exp_l [NF];
  logic [23:0] exp_r [NF];

  always #2 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk(bclk), .wclk(wclk),
    .sdata(sdata), .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  // handshake seen at negedge completes at the following posedge
  always @(negedge clk) begin
    if (!rst_n) got_n = 0;
    else if (out_valid && out_ready) begin
      if (got_n < 16) begin
        got_l[got_n] = out_left;
        got_r[got_n] = out_right;
      end
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic [31:0] pat(input int c, input int i, input int w);
    case (i % 4)
      0: return 32'h1 << (w - 1);
      1: return (32'h1 << (w - 1)) - 32'h1;
      2: return wmask(w);
      default: return (32'h9E37_79B9 * (c * 13 + i + 1)) & wmask(w);
    endcase
  endfunction

  function automatic logic [23:0] expect_of(input int f, input int w, input logic [31:0] v);
    if (f == 2) return v[23:0];
    if (f == 3) return {v[15:0], 8'h00};
    if (w >= 24) return 24'(v >> (w - 24));
    return 24'(v << (24 - w));
  endfunction

  task automatic put_bit(input logic ws, input logic d);
    @(negedge clk);
    bclk = 1'b0; wclk = ws; sdata = d;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic put_half(input int f, input bit left, input logic [31:0] v, input int w, input int s);
    logic ws;
    ws = (f == 0) ? !left : left;
    for (int k = 0; k < s; k++) begin
      logic d;
      d = 1'b0;
      if (f == 0) begin
        if (k >= 1 && k <= w) d = v[w - k];
      end else if (f == 1) begin
        if (k < w) d = v[w - 1 - k];
      end else begin
        if (k >= s - w) d = v[s - 1 - k];
      end
      put_bit(ws, d);
    end
  endtask

  task automatic do_reset(input int f);
    rst_n = 1'b0;
    fmt_sel = 2'(f);
    bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stream(input int f, input int w, input int s, input int c);
    put_half(f, 1'b1, pat(c, 7, w), w, s);
    put_half(f, 1'b0, pat(c, 6, w), w, s);
    for (int i = 0; i < NF; i++) begin
      logic [31:0] lv, rv;
      lv = pat(c, i, w);
      rv = pat(c, i + 5, w);
      exp_l[i] = expect_of(f, w, lv);
      exp_r[i] = expect_of(f, w, rv);
      put_half(f, 1'b1, lv, w, s);
      put_half(f, 1'b0, rv, w, s);
    end
    put_half(f, 1'b1, 32'h0, w, s);
    put_half(f, 1'b0, 32'h0, w, s);
    repeat (10) @(negedge clk);
  endtask

  task automatic run_case(input int f, input int w, input int s, input int c, input string tag);
    do_reset(f);
    stream(f, w, s, c);
    chk(got_n == NF, {tag, " R7 pair count"}, got_n, NF);
    for (int i = 0; i < NF; i++) begin
      chk(got_l[i] == exp_l[i], {tag, " left"}, {8'h0, got_l[i]}, {8'h0, exp_l[i]});
      chk(got_r[i] == exp_r[i], {tag, " right"}, {8'h0, got_r[i]}, {8'h0, exp_r[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    do_reset(1);
    chk(out_valid == 1'b0, "R9 valid after reset", {31'h0, out_valid}, 32'h0);
    chk(out_left == 24'h0, "R9 left after reset", {8'h0, out_left}, 32'h0);
    chk(out_right == 24'h0, "R9 right after reset", {8'h0, out_right}, 32'h0);

    run_case(0, 16, 32, 1, "R1 R6 i2s w16");
    run_case(0, 24, 32, 2, "R1 i2s w24");
    run_case(0, 28, 32, 3, "R1 R5 i2s w28");
    run_case(1, 16, 32, 4, "R2 R6 lj w16");
    run_case(1, 24, 32, 5, "R2 lj w24");
    run_case(1, 32, 32, 6, "R2 R5 lj w32");
    run_case(1, 24, 24, 7, "R2 lj w24 slot24");
    run_case(2, 24, 32, 8, "R3 rj24 slot32");
    run_case(2, 24, 24, 9, "R3 rj24 slot24");
    run_case(3, 16, 32, 10, "R4 rj16 slot32");
    run_case(3, 16, 16, 11, "R4 rj16 slot16");

    // R8: stalled consumer, newer pairs replace the held one
    do_reset(1);
    @(posedge clk); #1 out_ready = 1'b0;
    stream(1, 24, 32, 12);
    chk(out_valid == 1'b1, "R8 valid held while stalled", {31'h0, out_valid}, 32'h1);
    chk(got_n == 0, "R8 nothing taken while stalled", got_n, 0);
    chk(out_left == exp_l[NF-1], "R8 held left is newest", {8'h0, out_left}, {8'h0, exp_l[NF-1]});
    chk(out_right == exp_r[NF-1], "R8 held right is newest", {8'h0, out_right}, {8'h0, exp_r[NF-1]});
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(got_n == 1, "R8 single transfer after release", got_n, 1);
    chk(got_l[0] == exp_l[NF-1], "R8 taken left", {8'h0, got_l[0]}, {8'h0, exp_l[NF-1]});
    chk(out_valid == 1'b0, "R8 valid drops after accept", {31'h0, out_valid}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule